// File: doc/BRIEF.md
# Blit Address Sequencer

This block is the control front end of a rectangle copy engine. Software programs a handful of 32-bit registers through a write port: line pitches for the source and target surfaces, the source and target start addresses, a pointer to an 8x8 pattern tile, a control word, and finally a size word. Writing the size word launches the operation. The engine then walks the rectangle one byte at a time. For every byte it first asks for a read of the source byte, then asks for a write of the target byte, over a valid/ready memory request port.

Alongside each request the block presents the pattern tile pointer and the current tile row and column, so a separate pixel datapath can fetch and combine pattern data. The walk may run left-to-right or right-to-left, and top-to-bottom or bottom-to-top, with each direction chosen on its own. The two surfaces have separate pitches. A status bit in the control readback shows whether a walk is running.

Top module: `blit_seq`

## Requirements
- R1: Register index on `wr_sel`/`rd_sel`: 0 = pitch, 1 = source address, 2 = target address, 3 = pattern pointer, 4 = control, 5 = size. All registers read as zero after reset. The pitch register keeps the source pitch in bits 11:0 and the target pitch in bits 27:16, and every other bit reads as zero.
- R2: The source, target and pattern pointer registers keep only bits 20:0 of the written word and read back zero above bit 20. The pattern pointer is presented on `pat_base`.
- R3: A write to the size register (bytes per line in bits 11:0, line count in bits 27:16) with both counts nonzero starts a walk. `busy` and control readback bit 20 are 1 from the next cycle until the walk ends.
- R4: Each byte produces a read request (`mem_write`=0, source address) followed by a write request (`mem_write`=1, target address). A request holds its address and type while `mem_ready` is low.
- R5: With control bit 9 = 1 the address rises by 1 per byte. With control bit 8 = 1 each new line starts one pitch above the previous line start. The source uses the source pitch and the target uses the target pitch.
- R6: With control bit 9 = 0 the address falls by 1 per byte. With control bit 8 = 0 each new line starts one pitch below the previous line start. The programmed addresses are where the first line starts, and addresses wrap modulo 2^21.
- R7: `pat_row` equals control bits 18:16 on the first line and rises by one, modulo 8, on each new line. `pat_col` is the byte's position within the line, modulo 8.
- R8: Register writes that arrive while `busy` is 1 are ignored.
- R9: A size write with a zero byte count or a zero line count leaves the block idle and issues no memory request.
- R10: `busy` returns to 0 in the cycle after the last byte's write request is accepted, and `mem_valid` is 0 whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register index for writes |
| wr_data | input | 32 | Register write data |
| rd_sel | input | 3 | Register index for reads |
| rd_data | output | 32 | Register read data (combinational) |
| busy | output | 1 | Walk in progress |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 0 = source read, 1 = target write |
| mem_addr | output | 21 | Byte address of the request |
| mem_ready | input | 1 | Memory accepts the request |
| pat_base | output | 21 | Pattern tile pointer |
| pat_row | output | 3 | Current pattern row |
| pat_col | output | 3 | Current pattern column |

## Verification
The bench walks rectangles in all four direction combinations. It checks each request address, the start address of each new line, and the row wrap from 7 to 0 and the column wrap after eight bytes. If a line step used the wrong pitch or the wrong sign, the first address of the second line would be wrong. If a sequencer skipped the initial row load, `pat_row` would be wrong on the very first byte. Stalls with `mem_ready` low show whether a request holds steady or advances early. Writes made during a walk, and size writes with a zero count, catch a design that changes its setup in mid-walk or that issues requests for an empty rectangle.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef enum logic [2:0] {
    SEL_PITCH = 3'd0,
    SEL_SRC   = 3'd1,
    SEL_DST   = 3'd2,
    SEL_PAT   = 3'd3,
    SEL_CTRL  = 3'd4,
    SEL_SIZE  = 3'd5
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } walk_state_e;

  localparam int CTL_YINC_BIT = 8;
  localparam int CTL_XINC_BIT = 9;
  localparam int CTL_ROW_LSB  = 16;
  localparam int CTL_BUSY_BIT = 20;
  localparam int HI_FIELD_LSB = 16;
  localparam int PAT_IDX_W    = 3;
endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int AW = 21,
  parameter int PW = 12,
  parameter int CW = 12,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           wr_sel,
  input  logic [DW-1:0]        wr_data,
  input  logic [2:0]           rd_sel,
  input  logic                 busy,
  output logic [DW-1:0]        rd_data,
  output logic [AW-1:0]        src_base,
  output logic [AW-1:0]        dst_base,
  output logic [AW-1:0]        pat_base,
  output logic [PW-1:0]        src_pitch,
  output logic [PW-1:0]        dst_pitch,
  output logic [CW-1:0]        width,
  output logic [CW-1:0]        height,
  output logic                 x_inc,
  output logic                 y_inc,
  output logic [PAT_IDX_W-1:0] row0,
  output logic                 start
);
  localparam int CTLW = CTL_BUSY_BIT;

  logic [AW-1:0]   src_q, src_d, dst_q, dst_d, pat_q, pat_d;
  logic [PW-1:0]   sp_q, sp_d, dp_q, dp_d;
  logic [CW-1:0]   w_q, w_d, h_q, h_d;
  logic [CTLW-1:0] ctl_q, ctl_d;
  logic            wr_ok;
  logic [CW-1:0]   new_w, new_h;

  assign wr_ok = wr_en && !busy;
  assign new_w = wr_data[CW-1:0];
  assign new_h = wr_data[HI_FIELD_LSB+CW-1:HI_FIELD_LSB];

  always_comb begin
    src_d = src_q;
    dst_d = dst_q;
    pat_d = pat_q;
    sp_d  = sp_q;
    dp_d  = dp_q;
    w_d   = w_q;
    h_d   = h_q;
    ctl_d = ctl_q;
    if (wr_ok) begin
      case (wr_sel)
        SEL_PITCH: begin
          sp_d = wr_data[PW-1:0];
          dp_d = wr_data[HI_FIELD_LSB+PW-1:HI_FIELD_LSB];
        end
        SEL_SRC:  src_d = wr_data[AW-1:0];
        SEL_DST:  dst_d = wr_data[AW-1:0];
        SEL_PAT:  pat_d = wr_data[AW-1:0];
        SEL_CTRL: ctl_d = wr_data[CTLW-1:0];
        SEL_SIZE: begin
          w_d = new_w;
          h_d = new_h;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      pat_q <= '0;
      sp_q  <= '0;
      dp_q  <= '0;
      w_q   <= '0;
      h_q   <= '0;
      ctl_q <= '0;
    end else if (wr_ok) begin
      src_q <= src_d;
      dst_q <= dst_d;
      pat_q <= pat_d;
      sp_q  <= sp_d;
      dp_q  <= dp_d;
      w_q   <= w_d;
      h_q   <= h_d;
      ctl_q <= ctl_d;
    end
  end

  assign start = wr_ok && (wr_sel == SEL_SIZE) && (new_w != '0) && (new_h != '0);

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_PITCH: begin
        rd_data[PW-1:0] = sp_q;
        rd_data[HI_FIELD_LSB+PW-1:HI_FIELD_LSB] = dp_q;
      end
      SEL_SRC:  rd_data[AW-1:0] = src_q;
      SEL_DST:  rd_data[AW-1:0] = dst_q;
      SEL_PAT:  rd_data[AW-1:0] = pat_q;
      SEL_CTRL: begin
        rd_data[CTLW-1:0]    = ctl_q;
        rd_data[CTL_BUSY_BIT] = busy;
      end
      SEL_SIZE: begin
        rd_data[CW-1:0] = w_q;
        rd_data[HI_FIELD_LSB+CW-1:HI_FIELD_LSB] = h_q;
      end
      default: ;
    endcase
  end

  assign src_base  = src_q;
  assign dst_base  = dst_q;
  assign pat_base  = pat_q;
  assign src_pitch = sp_q;
  assign dst_pitch = dp_q;
  assign width     = w_q;
  assign height    = h_q;
  assign x_inc     = ctl_q[CTL_XINC_BIT];
  assign y_inc     = ctl_q[CTL_YINC_BIT];
  assign row0      = ctl_q[CTL_ROW_LSB+PAT_IDX_W-1:CTL_ROW_LSB];
endmodule

// File: rtl/blit_addr_step.sv
module blit_addr_step #(
  parameter int AW = 21,
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [PW-1:0] pitch,
  input  logic          x_inc,
  input  logic          y_inc,
  input  logic          step_byte,
  input  logic          step_line,
  output logic [AW-1:0] addr
);
  localparam int PAD = AW - PW;

  logic [AW-1:0] line_q, line_d, cur_q, cur_d;
  logic [AW-1:0] pitch_ext, next_line;
  logic          en;

  assign pitch_ext = {{PAD{1'b0}}, pitch};
  assign next_line = y_inc ? (line_q + pitch_ext) : (line_q - pitch_ext);
  assign en        = load || step_byte || step_line;

  always_comb begin
    line_d = line_q;
    cur_d  = cur_q;
    if (load) begin
      line_d = base;
      cur_d  = base;
    end else if (step_line) begin
      line_d = next_line;
      cur_d  = next_line;
    end else if (step_byte) begin
      cur_d = x_inc ? (cur_q + 1'b1) : (cur_q - 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      cur_q  <= '0;
    end else if (en) begin
      line_q <= line_d;
      cur_q  <= cur_d;
    end
  end

  assign addr = cur_q;
endmodule

// File: rtl/blit_walker.sv
module blit_walker
  import blit_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CW-1:0]        width,
  input  logic [CW-1:0]        height,
  input  logic [PAT_IDX_W-1:0] row0,
  input  logic                 mem_ready,
  output logic                 busy,
  output logic                 mem_valid,
  output logic                 mem_write,
  output logic                 load,
  output logic                 step_byte,
  output logic                 step_line,
  output logic [PAT_IDX_W-1:0] pat_row,
  output logic [PAT_IDX_W-1:0] pat_col
);
  walk_state_e          st_q, st_d;
  logic [CW-1:0]        x_q, x_d, y_q, y_d;
  logic [PAT_IDX_W-1:0] row_q, row_d;
  logic                 last_x, last_y, en;

  assign last_x = (x_q == width - 1'b1);
  assign last_y = (y_q == height - 1'b1);

  always_comb begin
    st_d      = st_q;
    x_d       = x_q;
    y_d       = y_q;
    row_d     = row_q;
    load      = 1'b0;
    step_byte = 1'b0;
    step_line = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          load  = 1'b1;
          st_d  = ST_READ;
          x_d   = '0;
          y_d   = '0;
          row_d = row0;
        end
      end
      ST_READ: begin
        if (mem_ready) st_d = ST_WRITE;
      end
      ST_WRITE: begin
        if (mem_ready) begin
          if (last_x) begin
            if (last_y) begin
              st_d = ST_IDLE;
            end else begin
              step_line = 1'b1;
              x_d   = '0;
              y_d   = y_q + 1'b1;
              row_d = row_q + 1'b1;
              st_d  = ST_READ;
            end
          end else begin
            step_byte = 1'b1;
            x_d  = x_q + 1'b1;
            st_d = ST_READ;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign en = (st_q != ST_IDLE) ? mem_ready : start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      x_q   <= '0;
      y_q   <= '0;
      row_q <= '0;
    end else if (en) begin
      st_q  <= st_d;
      x_q   <= x_d;
      y_q   <= y_d;
      row_q <= row_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign mem_valid = busy;
  assign mem_write = (st_q == ST_WRITE);
  assign pat_row   = row_q;
  assign pat_col   = x_q[PAT_IDX_W-1:0];
endmodule

// File: rtl/blit_seq.sv
module blit_seq
  import blit_pkg::*;
#(
  parameter int AW = 21,
  parameter int PW = 12,
  parameter int CW = 12,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           wr_sel,
  input  logic [DW-1:0]        wr_data,
  input  logic [2:0]           rd_sel,
  output logic [DW-1:0]        rd_data,
  output logic                 busy,
  output logic                 mem_valid,
  output logic                 mem_write,
  output logic [AW-1:0]        mem_addr,
  input  logic                 mem_ready,
  output logic [AW-1:0]        pat_base,
  output logic [PAT_IDX_W-1:0] pat_row,
  output logic [PAT_IDX_W-1:0] pat_col
);
  localparam int NCH = 2;

  logic                 rst_meta, rst_q;
  logic [AW-1:0]        base_a  [NCH];
  logic [PW-1:0]        pitch_a [NCH];
  logic [AW-1:0]        addr_a  [NCH];
  logic                 x_inc, y_inc, start, load, step_byte, step_line;
  logic [CW-1:0]        width, height;
  logic [PAT_IDX_W-1:0] row0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  blit_regs #(.AW(AW), .PW(PW), .CW(CW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_q),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .rd_sel    (rd_sel),
    .busy      (busy),
    .rd_data   (rd_data),
    .src_base  (base_a[0]),
    .dst_base  (base_a[1]),
    .pat_base  (pat_base),
    .src_pitch (pitch_a[0]),
    .dst_pitch (pitch_a[1]),
    .width     (width),
    .height    (height),
    .x_inc     (x_inc),
    .y_inc     (y_inc),
    .row0      (row0),
    .start     (start)
  );

  blit_walker #(.CW(CW)) u_walk (
    .clk       (clk),
    .rst_n     (rst_q),
    .start     (start),
    .width     (width),
    .height    (height),
    .row0      (row0),
    .mem_ready (mem_ready),
    .busy      (busy),
    .mem_valid (mem_valid),
    .mem_write (mem_write),
    .load      (load),
    .step_byte (step_byte),
    .step_line (step_line),
    .pat_row   (pat_row),
    .pat_col   (pat_col)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    blit_addr_step #(.AW(AW), .PW(PW)) u_step (
      .clk       (clk),
      .rst_n     (rst_q),
      .load      (load),
      .base      (base_a[ch]),
      .pitch     (pitch_a[ch]),
      .x_inc     (x_inc),
      .y_inc     (y_inc),
      .step_byte (step_byte),
      .step_line (step_line),
      .addr      (addr_a[ch])
    );
  end

  assign mem_addr = mem_write ? addr_a[1] : addr_a[0];
endmodule

// File: rtl/blit_seq_chk.sv
module blit_seq_chk #(
  parameter int AW = 21,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    wr_sel,
  input logic [DW-1:0] wr_data,
  input logic [2:0]    rd_sel,
  input logic [DW-1:0] rd_data,
  input logic          busy,
  input logic          mem_valid,
  input logic          mem_write,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ready,
  input logic [AW-1:0] pat_base
);
  logic size_wr, nonzero;
  assign size_wr = wr_en && (wr_sel == 3'd5) && !busy;
  assign nonzero = (wr_data[11:0] != 12'd0) && (wr_data[27:16] != 12'd0);

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    size_wr && nonzero |=> busy); // R3
  AST_STATUS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 3'd4) |-> (rd_data[20] == busy)); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write)); // R4
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_write && mem_ready |=> mem_valid && mem_write); // R4
  AST_WRITE_THEN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write && mem_ready |=> !mem_write); // R4
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pat_base)); // R8
  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    size_wr && !nonzero |=> !busy); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid); // R10
endmodule

bind blit_seq blit_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .rd_sel    (rd_sel),
  .rd_data   (rd_data),
  .busy      (busy),
  .mem_valid (mem_valid),
  .mem_write (mem_write),
  .mem_addr  (mem_addr),
  .mem_ready (mem_ready),
  .pat_base  (pat_base)
);

// File: tb/blit_seq_test.sv
module blit_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic [2:0]  rd_sel = 3'd0;
  logic [31:0] rd_data;
  logic        busy, mem_valid, mem_write;
  logic [20:0] mem_addr, pat_base;
  logic        mem_ready = 1'b0;
  logic [2:0]  pat_row, pat_col;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  blit_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .busy(busy), .mem_valid(mem_valid),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .pat_base(pat_base), .pat_row(pat_row), .pat_col(pat_col)
  );

  typedef struct packed {
    logic [20:0] src;
    logic [20:0] dst;
    logic [11:0] sp;
    logic [11:0] dp;
    logic [11:0] w;
    logic [11:0] h;
    logic        xi;
    logic        yi;
    logic [2:0]  row;
    logic [20:0] last_dst;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{21'h01000, 21'h02000, 12'd16, 12'd32, 12'd3,  12'd2, 1'b1, 1'b1, 3'd0, 21'h02022},
    '{21'h0100F, 21'h03007, 12'd20, 12'd8,  12'd4,  12'd3, 1'b0, 1'b0, 3'd6, 21'h02FF4},
    '{21'h00500, 21'h00800, 12'd10, 12'd12, 12'd10, 12'd2, 1'b1, 1'b0, 3'd7, 21'h007FD},
    '{21'h00001, 21'h000FF, 12'd4,  12'd4,  12'd3,  12'd2, 1'b0, 1'b1, 3'd3, 21'h00101}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] sel, input logic [31:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] sel, output logic [31:0] val);
    rd_sel = sel;
    #1;
    val = rd_data;
  endtask

  function automatic logic [20:0] walk_addr(input logic [20:0] base, input logic [11:0] pitch,
                                            input bit xi, input bit yi, input int x, input int y);
    logic [20:0] oy, ox, a;
    oy = 21'(y * pitch);
    ox = 21'(x);
    a  = yi ? base + oy : base - oy;
    return xi ? a + ox : a - ox;
  endfunction

  // one request: wait for valid, optionally stall, check, then accept
  task automatic take(input bit exp_wr, input logic [20:0] exp_addr, input logic [2:0] exp_row,
                      input logic [2:0] exp_col, input int stall, output logic [20:0] seen);
    int guard = 0;
    while (!mem_valid && guard < 20) begin @(negedge clk); guard++; end
    check(mem_valid, "R4 valid", 32'(mem_valid), 32'd1);
    check(mem_write == exp_wr, "R4 type", 32'(mem_write), 32'(exp_wr));
    check(mem_addr == exp_addr, exp_wr ? "R5/R6 target addr" : "R5/R6 source addr",
          32'(mem_addr), 32'(exp_addr));
    check(pat_row == exp_row, "R7 row", 32'(pat_row), 32'(exp_row));
    check(pat_col == exp_col, "R7 col", 32'(pat_col), 32'(exp_col));
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(mem_valid && mem_write == exp_wr && mem_addr == exp_addr, "R4 hold",
            32'(mem_addr), 32'(exp_addr));
    end
    seen = mem_addr;
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
  endtask

  task automatic run_walk(input vec_t v, input bit probe_busy_write);
    logic [31:0] r;
    logic [20:0] seen, last;
    last = '0;
    wreg(3'd0, {4'd0, v.dp, 4'd0, v.sp});
    wreg(3'd1, 32'(v.src));
    wreg(3'd2, 32'(v.dst));
    wreg(3'd4, (32'(v.row) << 16) | (32'(v.xi) << 9) | (32'(v.yi) << 8));
    wreg(3'd5, {4'd0, v.h, 4'd0, v.w});
    rreg(3'd4, r);
    check(r[20] == 1'b1 && busy, "R3 status bit during walk", r, 32'h100000);
    if (probe_busy_write) begin
      wreg(3'd1, 32'h00123);  // R8: ignored while busy
      wreg(3'd3, 32'h0ABCD);
    end
    for (int y = 0; y < int'(v.h); y++) begin
      for (int x = 0; x < int'(v.w); x++) begin
        take(1'b0, walk_addr(v.src, v.sp, v.xi, v.yi, x, y), 3'(int'(v.row) + y), 3'(x),
             (x == 1) ? 2 : 0, seen);
        take(1'b1, walk_addr(v.dst, v.dp, v.xi, v.yi, x, y), 3'(int'(v.row) + y), 3'(x),
             (y == 0 && x == 0) ? 1 : 0, seen);
        last = seen;
      end
    end
    check(last == v.last_dst, "R5/R6 final target addr", 32'(last), 32'(v.last_dst));
    check(!busy && !mem_valid, "R10 idle after last write", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(!busy && !mem_valid, "R1 reset idle", 32'(busy), 32'd0);
    rreg(3'd0, r); check(r == 32'd0, "R1 reset pitch", r, 32'd0);
    rreg(3'd4, r); check(r == 32'd0, "R1 reset control", r, 32'd0);

    // R1 pitch field masking
    wreg(3'd0, 32'hFFFF_FFFF);
    rreg(3'd0, r); check(r == 32'h0FFF_0FFF, "R1 pitch fields", r, 32'h0FFF_0FFF);

    // R2 address masking
    wreg(3'd1, 32'hFFFF_FFFF);
    rreg(3'd1, r); check(r == 32'h001F_FFFF, "R2 source mask", r, 32'h001F_FFFF);
    wreg(3'd2, 32'hABE0_1234);
    rreg(3'd2, r); check(r == 32'h0000_1234, "R2 target mask", r, 32'h0000_1234);
    wreg(3'd3, 32'hFFF5_5555);
    rreg(3'd3, r); check(r == 32'h0015_5555, "R2 pattern mask", r, 32'h0015_5555);
    check(pat_base == 21'h15_5555, "R2 pat_base port", 32'(pat_base), 32'h155555);

    // vector table, all four direction pairs
    for (int v = 0; v < 4; v++) run_walk(VECS[v], 1'b0);

    // R8 writes during a walk are ignored
    wreg(3'd3, 32'h0000_0040);
    run_walk(VECS[0], 1'b1);
    rreg(3'd1, r); check(r == 32'(VECS[0].src), "R8 source unchanged", r, 32'(VECS[0].src));
    check(pat_base == 21'h40, "R8 pattern unchanged", 32'(pat_base), 32'h40);

    // R9 zero counts
    wreg(3'd5, {4'd0, 12'd5, 4'd0, 12'd0});
    check(!busy && !mem_valid, "R9 zero width", 32'(busy), 32'd0);
    repeat (3) @(negedge clk);
    check(!mem_valid, "R9 zero width no request", 32'(mem_valid), 32'd0);
    wreg(3'd5, {4'd0, 12'd0, 4'd0, 12'd7});
    check(!busy && !mem_valid, "R9 zero height", 32'(busy), 32'd0);
    repeat (3) @(negedge clk);
    rreg(3'd4, r); check(r[20] == 1'b0, "R9 status idle", r, 32'd0);

    // R3 single byte walk
    run_walk('{21'h00010, 21'h00020, 12'd1, 12'd1, 12'd1, 12'd1, 1'b1, 1'b1, 3'd5, 21'h00020}, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule